// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects change events from three groups of live per-channel status inputs into sticky status bits. The groups are loss of signal, driver fault and alarm indication. A single interrupt output pulls low while any enabled sticky bit is pending. The output is modelled as a pull-down enable, so that several such outputs can share one line with an external pull-up.

A sticky bit latches when its live input changes level, on either edge, provided its enable bit is set. Software finds the source by reading one of three sticky status addresses. That read returns the latched bits and clears the whole group. Reading the live monitor address of a group returns the current input levels and also clears that group's sticky bits. A clear happens only on the rising edge of the read strobe. An event that arrives in the same cycle as its clear is kept. The interrupt output is registered from the OR of all sticky bits that are currently enabled.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: After reset the interrupt pull-down enable `int_pull_o` is 0 and `rd_data_o` is 0.
- R2: A level change in either direction on an enabled live input bit sets its sticky bit at the next clock edge. `int_pull_o` goes to 1 at the edge after that.
- R3: A change on a live input bit whose enable is 0 sets no sticky bit and raises no interrupt.
- R4: At each clock edge, `int_pull_o` is loaded with the OR of the sticky bits ANDed with `irq_en_i`. Enable bits are packed as {alarm, driver fault, loss of signal}, with NCH bits each and loss of signal in the lowest bits. Clearing an enable bit therefore releases the output one edge later without clearing the sticky bit.
- R5: A read of sticky address 0x08 (loss of signal), 0x09 (driver fault) or 0x15 (alarm) loads `rd_data_o` with that group's sticky bits at the edge that samples the strobe rising. It clears the group at the same edge.
- R6: A read of monitor address 0x04 (loss of signal), 0x05 (driver fault) or 0x13 (alarm) loads `rd_data_o` with the live input levels and clears that group's sticky bits. At most one group is cleared per read.
- R7: Clearing happens only on a rising edge of `rd_strobe_i`. Events that occur while the strobe stays high remain latched.
- R8: An event in the same cycle as the clear of its group leaves its sticky bit set.
- R9: Address bits above bit 5 are ignored by the decoder.
- R10: A read of any other address returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| los_i | input | NCH | Live loss-of-signal levels |
| dfm_i | input | NCH | Live driver fault levels |
| ais_i | input | NCH | Live alarm indication levels |
| irq_en_i | input | 3*NCH | Event enable bits, {alarm, driver fault, loss of signal} |
| rd_addr_i | input | ADDR_W | Read address |
| rd_strobe_i | input | 1 | Read strobe; its rising edge performs the read |
| rd_data_o | output | NCH | Data captured by the last read |
| int_pull_o | output | 1 | 1 drives the shared active-low interrupt line low |

## Verification
An input change driven between edges is latched at the first edge that follows. The interrupt output reflects that bit one edge later, two cycles after the stimulus. Read data is due one cycle after the strobe rises, and a clear shows on the interrupt output two cycles after the strobe rises. A change of the enable mask shows one cycle later. The scoreboard tags every expected item with the cycle number in which it is due. The monitor compares each item only in that cycle, on the falling clock edge.

// File: rtl/sisc_pkg.sv
package sisc_pkg;
  localparam int NSRC  = 3;
  localparam int DEC_W = 6;

  typedef enum logic [1:0] {
    SRC_LOS = 2'd0,
    SRC_DFM = 2'd1,
    SRC_AIS = 2'd2
  } src_e;

  localparam logic [DEC_W-1:0] A_STK_LOS = 6'h08;
  localparam logic [DEC_W-1:0] A_STK_DFM = 6'h09;
  localparam logic [DEC_W-1:0] A_STK_AIS = 6'h15;
  localparam logic [DEC_W-1:0] A_MON_LOS = 6'h04;
  localparam logic [DEC_W-1:0] A_MON_DFM = 6'h05;
  localparam logic [DEC_W-1:0] A_MON_AIS = 6'h13;

  typedef struct packed {
    logic             hit;
    logic             live;
    logic [1:0]       src;
  } dec_t;

  function automatic dec_t decode(input logic [DEC_W-1:0] a);
    dec_t d;
    d = '0;
    case (a)
      A_STK_LOS: begin d.hit = 1'b1; d.live = 1'b0; d.src = SRC_LOS; end
      A_STK_DFM: begin d.hit = 1'b1; d.live = 1'b0; d.src = SRC_DFM; end
      A_STK_AIS: begin d.hit = 1'b1; d.live = 1'b0; d.src = SRC_AIS; end
      A_MON_LOS: begin d.hit = 1'b1; d.live = 1'b1; d.src = SRC_LOS; end
      A_MON_DFM: begin d.hit = 1'b1; d.live = 1'b1; d.src = SRC_DFM; end
      A_MON_AIS: begin d.hit = 1'b1; d.live = 1'b1; d.src = SRC_AIS; end
      default:   d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sisc_rst_sync.sv
module sisc_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sisc_src_latch.sv
module sisc_src_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  output logic [W-1:0] sticky_o,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] sticky_q, sticky_d;
  logic [W-1:0] evt;

  always_comb begin
    evt      = (live_i ^ prev_q) & en_i;
    prev_d   = live_i;
    sticky_d = (sticky_q & {W{~clr_i}}) | evt;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  assign sticky_o = sticky_q;
  assign evt_o    = evt;
endmodule

// File: rtl/sisc_rd_port.sv
module sisc_rd_port
  import sisc_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 stb_i,
  input  logic [NSRC*W-1:0]    sticky_i,
  input  logic [NSRC*W-1:0]    live_i,
  output logic [NSRC-1:0]      clr_o,
  output logic                 rise_o,
  output logic [W-1:0]         data_o
);
  logic          stb_q;
  logic          rise;
  dec_t          dec;
  logic [W-1:0]  sel_data;
  logic [W-1:0]  data_q, data_d;
  logic          data_en;

  always_comb begin
    rise     = stb_i & ~stb_q;
    dec      = decode(addr_i[DEC_W-1:0]);
    sel_data = '0;
    clr_o    = '0;
    if (dec.hit) begin
      if (dec.live) sel_data = live_i[int'(dec.src)*W +: W];
      else          sel_data = sticky_i[int'(dec.src)*W +: W];
      if (rise) clr_o[dec.src] = 1'b1;
    end
    data_en = rise;
    data_d  = sel_data;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      data_q <= '0;
    end else begin
      stb_q <= stb_i;
      if (data_en) data_q <= data_d;
    end
  end

  assign rise_o = rise;
  assign data_o = data_q;
endmodule

// File: rtl/sisc_irq_out.sv
module sisc_irq_out #(
  parameter int N = 24
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [N-1:0] sticky_i,
  input  logic [N-1:0] en_i,
  output logic         pull_o
);
  logic pend, pull_q;

  always_comb pend = |(sticky_i & en_i);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= pend;
  end

  assign pull_o = pull_q;
endmodule

// File: rtl/sticky_irq_ctrl.sv
module sticky_irq_ctrl
  import sisc_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic [NCH-1:0]       los_i,
  input  logic [NCH-1:0]       dfm_i,
  input  logic [NCH-1:0]       ais_i,
  input  logic [NSRC*NCH-1:0]  irq_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic                 rd_strobe_i,
  output logic [NCH-1:0]       rd_data_o,
  output logic                 int_pull_o
);
  localparam int TOT = NSRC * NCH;

  logic            rst_sync_n;
  logic [TOT-1:0]  live_all;
  logic [TOT-1:0]  sticky_all;
  logic [TOT-1:0]  evt_all;
  logic [NSRC-1:0] clr_grp;
  logic            rd_rise;

  assign live_all = {ais_i, dfm_i, los_i};

  sisc_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    sisc_src_latch #(.W(NCH)) u_latch (
      .clk_i    (clk_i),
      .rst_n    (rst_sync_n),
      .live_i   (live_all[s*NCH +: NCH]),
      .en_i     (irq_en_i[s*NCH +: NCH]),
      .clr_i    (clr_grp[s]),
      .sticky_o (sticky_all[s*NCH +: NCH]),
      .evt_o    (evt_all[s*NCH +: NCH])
    );
  end

  sisc_rd_port #(.W(NCH), .ADDR_W(ADDR_W)) u_rd (
    .clk_i    (clk_i),
    .rst_n    (rst_sync_n),
    .addr_i   (rd_addr_i),
    .stb_i    (rd_strobe_i),
    .sticky_i (sticky_all),
    .live_i   (live_all),
    .clr_o    (clr_grp),
    .rise_o   (rd_rise),
    .data_o   (rd_data_o)
  );

  sisc_irq_out #(.N(TOT)) u_irq (
    .clk_i    (clk_i),
    .rst_n    (rst_sync_n),
    .sticky_i (sticky_all),
    .en_i     (irq_en_i),
    .pull_o   (int_pull_o)
  );
endmodule

// File: rtl/sticky_irq_ctrl_chk.sv
module sticky_irq_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [3*NCH-1:0] sticky,
  input logic [3*NCH-1:0] evt,
  input logic [3*NCH-1:0] en,
  input logic [2:0]       clr,
  input logic             rise,
  input logic             pull
);
  assert_pull_set_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|(sticky & en)) |=> pull);

  assert_pull_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|(sticky & en)) |=> !pull);

  assert_event_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|evt) |=> ((sticky & $past(evt)) == $past(evt)));

  assert_masked_no_set_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((sticky & ~$past(sticky) & ~$past(en)) == '0));

  assert_no_clear_without_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rise |=> ((sticky & $past(sticky)) == $past(sticky)));

  assert_one_group_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(clr));

  for (genvar s = 0; s < 3; s++) begin : g_clr
    assert_group_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
      (clr[s] && !(|evt[s*NCH +: NCH])) |=> (sticky[s*NCH +: NCH] == '0));
  end
endmodule

bind sticky_irq_ctrl sticky_irq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_sync_n),
  .sticky (sticky_all),
  .evt    (evt_all),
  .en     (irq_en_i),
  .clr    (clr_grp),
  .rise   (rd_rise),
  .pull   (int_pull_o)
);

// File: tb/sticky_irq_ctrl_tb.sv
module sticky_irq_ctrl_tb;
  localparam int NCH = 8;
  localparam int AW  = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  los, dfm, ais;
  logic [3*NCH-1:0] en;
  logic [AW-1:0]   addr;
  logic            stb;
  logic [NCH-1:0]  rd_data;
  logic            pull;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int        due;
    bit        is_irq;
    logic [7:0] val;
    string     tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sticky_irq_ctrl #(.NCH(NCH), .ADDR_W(AW)) u_dut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .los_i       (los),
    .dfm_i       (dfm),
    .ais_i       (ais),
    .irq_en_i    (en),
    .rd_addr_i   (addr),
    .rd_strobe_i (stb),
    .rd_data_o   (rd_data),
    .int_pull_o  (pull)
  );

  task automatic push(input int dly, input bit is_irq, input logic [7:0] v, input string tag);
    item_t it;
    it.due = cyc + dly; it.is_irq = is_irq; it.val = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_now(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: compares each expected item in its due cycle
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        check_now(sb_q[i].is_irq ? {7'd0, pull} : rd_data, sb_q[i].val, sb_q[i].tag);
        sb_q.delete(i);
      end
    end
  end

  // driver: one read with rising strobe, data due next cycle, irq two cycles on
  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input bit exp_irq,
                         input string tag);
    addr = a; stb = 1'b1;
    push(1, 1'b0, exp, tag);
    push(2, 1'b1, {7'd0, exp_irq}, {tag, " irq"});
    tick();
    stb = 1'b0;
    tick();
  endtask

  initial begin
    rst_n = 1'b0; los = '0; dfm = '0; ais = '0; en = '1; addr = '0; stb = 1'b0;
    tick(3);
    check_now({7'd0, pull}, 8'h00, "R1 irq after reset");
    check_now(rd_data, 8'h00, "R1 data after reset");
    rst_n = 1'b1;
    tick(4);

    // R2: rising and falling edges both latch
    los = 8'h01; push(2, 1'b1, 8'h01, "R2 rise irq"); tick(3);
    do_read(8'h08, 8'h01, 1'b0, "R5 los sticky read");
    los = 8'h00; push(2, 1'b1, 8'h01, "R2 fall irq"); tick(3);
    do_read(8'h08, 8'h01, 1'b0, "R2 fall sticky");

    // R3: masked-off changes do nothing
    en = 24'hFFFF00; tick();
    los = 8'h0F; push(2, 1'b1, 8'h00, "R3 masked irq"); tick(3);
    do_read(8'h08, 8'h00, 1'b0, "R3 masked sticky");
    en = '1; tick(2);

    // R4: mask gates the output without clearing
    dfm = 8'h08; push(2, 1'b1, 8'h01, "R4 dfm irq"); tick(3);
    en = 24'hFF00FF; push(1, 1'b1, 8'h00, "R4 mask release"); tick(2);
    en = '1; push(1, 1'b1, 8'h01, "R4 mask restore"); tick(2);
    do_read(8'h05, 8'h08, 1'b0, "R6 dfm live read clears");

    // R8: event in same cycle as clear survives
    ais = 8'h20; push(2, 1'b1, 8'h01, "R2 ais irq"); tick(3);
    ais = 8'h24;
    do_read(8'h15, 8'h20, 1'b1, "R8 same-cycle read");
    do_read(8'h15, 8'h04, 1'b0, "R8 kept bit");

    // R7: strobe held high clears only once
    addr = 8'h13; stb = 1'b1; push(1, 1'b0, 8'h24, "R6 ais live read");
    tick();
    ais = 8'h25; push(2, 1'b1, 8'h01, "R7 event during held strobe");
    tick(4);
    stb = 1'b0; tick();
    do_read(8'h15, 8'h01, 1'b0, "R7 held strobe kept");

    // R9: upper address bits ignored
    los = 8'h8F; push(2, 1'b1, 8'h01, "R9 los irq"); tick(3);
    do_read(8'hC8, 8'h80, 1'b0, "R9 alias sticky read");
    do_read(8'h44, 8'h8F, 1'b0, "R9 alias live read");

    // R10: unmapped address reads zero, clears nothing
    dfm = 8'h09; push(2, 1'b1, 8'h01, "R10 dfm irq"); tick(3);
    do_read(8'h07, 8'h00, 1'b1, "R10 unmapped read");
    do_read(8'h09, 8'h01, 1'b0, "R10 sticky intact");

    tick(3);
    if (sb_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard items left actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule